// File: doc/BRIEF.md
# Maskable Status Interrupt Controller

This block collects status conditions from a network controller and turns them into one interrupt line. Two conditions are levels that the controller holds while they are true: transmitter available and receiver inhibited. Three are events that the controller reports as one-cycle set pulses: reconfiguration timeout, excessive negative acknowledges and new next-node ID. The block latches each event into a sticky status bit. Every sticky bit has its own clear strobe. Reconfiguration is cleared by the clear-flags command. Excessive-NAK is cleared by the power-on clear-flags command. New-next-ID is cleared by the strobe that reads the next-ID register. The level bits have no clear strobe and drop only when their source drops.

Software writes an 8-bit mask at register offset 0. A 1 in a mask bit enables the status bit at the same position. The registered interrupt output is the OR of the five status-and-mask products. Masking a level condition only hides it, so the interrupt returns when the mask bit is set again while the condition still holds. Address decoding above the register file belongs to the surrounding logic.

Top module: `stat_irq_ctrl`

## Requirements
- R1: The status read port places its bits as follows: bit 0 is transmitter available, bit 1 is receiver inhibited, bit 2 is reconfiguration, bit 3 is excessive-NAK and bit 4 is new-next-ID. Bits 7:5 always read 0. Bits 0 and 1 show the level inputs as they were one clock earlier.
- R2: A write with `wr_en_i` high and `wr_addr_i` equal to 0 loads the mask from bits 4:0 of the write data. Bits 7:5 are stored as 0 and read 0 on `mask_o`. A write to any other address leaves the mask unchanged.
- R3: `irq_o` is registered. One clock after any status or mask change it equals the OR over bits 4:0 of (status AND mask).
- R4: A level bit that is masked keeps `irq_o` low while the mask bit is 0. If the level is still high when the mask bit returns to 1, the interrupt reasserts.
- R5: A set pulse sets the reconfiguration bit, and the bit stays set until `clr_flags_i`. The power-on clear and the next-ID read strobe leave it unchanged.
- R6: A set pulse sets the excessive-NAK bit, and the bit stays set until `por_clr_i`. The clear-flags command and the next-ID read strobe leave it unchanged.
- R7: A set pulse sets the new-next-ID bit, and the bit stays set until `nnid_rd_i`. Neither flag-clear command changes it.
- R8: When a set pulse and the clear for the same bit arrive in the same cycle, the bit is set.
- R9: Reset drives status, mask and `irq_o` to 0. The clear-flags and power-on clear commands never change the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| txav_lvl_i | input | 1 | Transmitter-available level |
| rxinh_lvl_i | input | 1 | Receiver-inhibited level |
| rcfg_set_i | input | 1 | Reconfiguration timeout set pulse |
| nakx_set_i | input | 1 | Excessive-NAK set pulse |
| nnid_set_i | input | 1 | New-next-ID set pulse |
| clr_flags_i | input | 1 | Clear-flags command strobe |
| por_clr_i | input | 1 | Power-on clear-flags command strobe |
| nnid_rd_i | input | 1 | Next-ID register read strobe |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | ADDR_W (3) | Register write offset |
| wr_data_i | input | 8 | Register write data |
| status_o | output | 8 | Status read port |
| mask_o | output | 8 | Stored mask |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk` and holds a defined 0 or 1 at each rising edge. They also assume that `rst_n` is released away from the edge. They place no limit on how often events or strobes arrive, so sets, clears and writes may overlap in any combination. The stimulus changes inputs only on falling edges and holds every input at 0 during reset. After the directed phases it drives random pulses, collisions, levels and writes to both valid and invalid addresses, and a behavioural model is compared against the design on every clock.

// File: rtl/stat_irq_pkg.sv
package stat_irq_pkg;

  localparam int STAT_W    = 8;
  localparam int BIT_TXAV  = 0;
  localparam int BIT_RXINH = 1;
  localparam int BIT_RCFG  = 2;
  localparam int BIT_NAKX  = 3;
  localparam int BIT_NNID  = 4;
  localparam int N_STICKY  = 3;

  localparam logic [STAT_W-1:0] SRC_MASK =
    (STAT_W'(1) << BIT_TXAV) | (STAT_W'(1) << BIT_RXINH) |
    (STAT_W'(1) << BIT_RCFG) | (STAT_W'(1) << BIT_NAKX)  |
    (STAT_W'(1) << BIT_NNID);

  // Interrupt term: any enabled, implemented status bit.
  function automatic logic irq_reduce(input logic [STAT_W-1:0] st,
                                      input logic [STAT_W-1:0] mk);
    return |(st & mk & SRC_MASK);
  endfunction

  // Sticky bit update: a set always beats a clear.
  function automatic logic sticky_next(input logic q, input logic set,
                                       input logic clr);
    return set | (q & ~clr);
  endfunction

  // Keep only implemented mask positions.
  function automatic logic [STAT_W-1:0] mask_clean(input logic [STAT_W-1:0] d);
    return d & SRC_MASK;
  endfunction

endpackage

// File: rtl/stat_irq_sticky.sv
module stat_irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  import stat_irq_pkg::*;

  logic q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= sticky_next(q_r, set_i, clr_i);
  end

  assign q_o = q_r;

  // R8: a set in the same cycle as a clear leaves the bit set
  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);

  // R5 R6 R7: the own clear strobe empties the bit
  p_clear_only_own_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);

  // R5: without set or clear the bit holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/stat_irq_maskreg.sv
module stat_irq_maskreg #(
  parameter int ADDR_W    = 3,
  parameter int MASK_ADDR = 0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [stat_irq_pkg::STAT_W-1:0]   wr_data_i,
  output logic [stat_irq_pkg::STAT_W-1:0]   mask_o
);
  import stat_irq_pkg::*;

  localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(MASK_ADDR);

  logic              wr_hit;
  logic [STAT_W-1:0] mask_r;

  assign wr_hit = wr_en_i && (wr_addr_i == HIT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_r <= '0;
    else if (wr_hit) mask_r <= mask_clean(wr_data_i);
  end

  assign mask_o = mask_r;

  // R2: a missed or absent write leaves the mask untouched
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(mask_o));

  // R2: a write at the mask offset lands on the next clock
  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (mask_o[4:0] == $past(wr_data_i[4:0])));

  // R2: unused positions stay zero
  p_mask_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (mask_o[STAT_W-1:5] == '0));
endmodule

// File: rtl/stat_irq_combine.sv
module stat_irq_combine (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [stat_irq_pkg::STAT_W-1:0] status_i,
  input  logic [stat_irq_pkg::STAT_W-1:0] mask_i,
  output logic                            irq_o
);
  import stat_irq_pkg::*;

  logic irq_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= irq_reduce(status_i, mask_i);
  end

  assign irq_o = irq_r;

  // R3: output follows the enabled status one clock later
  p_irq_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == |($past(status_i[4:0]) & $past(mask_i[4:0]))));

  // R4: nothing enabled means no interrupt next clock
  p_irq_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_i[4:0] & mask_i[4:0]) == 5'd0) |=> !irq_o);
endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl #(
  parameter int ADDR_W    = 3,
  parameter int MASK_ADDR = 0
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            txav_lvl_i,
  input  logic                            rxinh_lvl_i,
  input  logic                            rcfg_set_i,
  input  logic                            nakx_set_i,
  input  logic                            nnid_set_i,
  input  logic                            clr_flags_i,
  input  logic                            por_clr_i,
  input  logic                            nnid_rd_i,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [stat_irq_pkg::STAT_W-1:0] wr_data_i,
  output logic [stat_irq_pkg::STAT_W-1:0] status_o,
  output logic [stat_irq_pkg::STAT_W-1:0] mask_o,
  output logic                            irq_o
);
  import stat_irq_pkg::*;

  // Sticky source table, index 0..N_STICKY-1
  localparam int STK_POS [N_STICKY] = '{BIT_RCFG, BIT_NAKX, BIT_NNID};

  logic [N_STICKY-1:0] stk_set, stk_clr, stk_q;
  logic                txav_q, rxinh_q;
  logic [STAT_W-1:0]   status_w, mask_w;

  assign stk_set = {nnid_set_i, nakx_set_i, rcfg_set_i};
  assign stk_clr = {nnid_rd_i,  por_clr_i,  clr_flags_i};

  // Level conditions: sampled, no clear of their own
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txav_q  <= 1'b0;
      rxinh_q <= 1'b0;
    end else begin
      txav_q  <= txav_lvl_i;
      rxinh_q <= rxinh_lvl_i;
    end
  end

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    stat_irq_sticky u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (stk_set[g]),
      .clr_i (stk_clr[g]),
      .q_o   (stk_q[g])
    );
  end

  always_comb begin
    status_w            = '0;
    status_w[BIT_TXAV]  = txav_q;
    status_w[BIT_RXINH] = rxinh_q;
    for (int i = 0; i < N_STICKY; i++) status_w[STK_POS[i]] = stk_q[i];
  end

  stat_irq_maskreg #(
    .ADDR_W    (ADDR_W),
    .MASK_ADDR (MASK_ADDR)
  ) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .mask_o    (mask_w)
  );

  stat_irq_combine u_comb (
    .clk      (clk),
    .rst_n    (rst_n),
    .status_i (status_w),
    .mask_i   (mask_w),
    .irq_o    (irq_o)
  );

  assign status_o = status_w;
  assign mask_o   = mask_w;

  // R1: level bits track their inputs one clock later
  p_level_track_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o[0] == $past(txav_lvl_i) && status_o[1] == $past(rxinh_lvl_i)));

  // R1: unused status positions stay zero
  p_status_unused_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (status_o[STAT_W-1:5] == '0));

  // R5: reconfiguration bit survives the other two clears
  p_rcfg_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[2] && !clr_flags_i) |=> status_o[2]);

  // R6: excessive-NAK bit survives the other two clears
  p_nakx_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[3] && !por_clr_i) |=> status_o[3]);

  // R9: flag commands never reach the mask
  p_cmd_no_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i && (clr_flags_i || por_clr_i)) |=> $stable(mask_o));
endmodule

// File: tb/stat_irq_ctrl_tb.sv
module stat_irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txav = 0, rxinh = 0, rcfg = 0, nakx = 0, nnid = 0;
  logic       clrf = 0, porc = 0, nrd = 0, wen = 0;
  logic [2:0] waddr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] status, mask;
  logic       irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Behavioural reference
  bit [7:0] m_stat = 0, m_mask = 0;
  bit       m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stat_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .txav_lvl_i(txav), .rxinh_lvl_i(rxinh),
    .rcfg_set_i(rcfg), .nakx_set_i(nakx), .nnid_set_i(nnid),
    .clr_flags_i(clrf), .por_clr_i(porc), .nnid_rd_i(nrd),
    .wr_en_i(wen), .wr_addr_i(waddr), .wr_data_i(wdata),
    .status_o(status), .mask_o(mask), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_mask = 0; m_irq = 0;
    end else begin
      bit [7:0] ns;
      m_irq = 0;
      for (int b = 0; b < 5; b++) if (m_stat[b] && m_mask[b]) m_irq = 1;
      ns = m_stat;
      ns[0] = txav;
      ns[1] = rxinh;
      if (rcfg) ns[2] = 1; else if (clrf) ns[2] = 0;
      if (nakx) ns[3] = 1; else if (porc) ns[3] = 0;
      if (nnid) ns[4] = 1; else if (nrd)  ns[4] = 0;
      m_stat = ns;
      if (wen && waddr == 0) m_mask = {3'b000, wdata[4:0]};
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Model comparison on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk("R1 status", status, m_stat);
      chk("R2 mask", mask, m_mask);
      chk("R3 irq", irq, m_irq);
    end
  end

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wen = 1; waddr = a; wdata = d; step(); wen = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    chk("R9 reset status", status, 0);
    chk("R9 reset mask", mask, 0);
    chk("R9 reset irq", irq, 0);

    // R2 mask load and unused bits
    wr(0, 8'hFF);
    chk("R2 unused mask bits", mask, 8'h1F);
    wr(3'd1, 8'h00);
    chk("R2 other address ignored", mask, 8'h1F);

    // R3 level to interrupt
    txav = 1; step();
    chk("R1 txav bit0", status, 8'h01);
    step();
    chk("R3 irq after txav", irq, 1);

    // R4 hide then reappear
    wr(0, 8'h1E); step();
    chk("R4 masked level hidden", irq, 0);
    wr(0, 8'h1F); step();
    chk("R4 unmasked level reasserts", irq, 1);
    txav = 0; step(2);
    chk("R3 irq drops with level", irq, 0);

    // R5 reconfiguration bit
    rcfg = 1; step(); rcfg = 0;
    chk("R5 rcfg set", status, 8'h04);
    porc = 1; nrd = 1; step(); porc = 0; nrd = 0;
    chk("R5 other clears ignored", status, 8'h04);
    clrf = 1; step(); clrf = 0;
    chk("R5 clear flags", status, 8'h00);

    // R6 excessive-NAK bit
    nakx = 1; step(); nakx = 0;
    clrf = 1; nrd = 1; step(); clrf = 0; nrd = 0;
    chk("R6 other clears ignored", status, 8'h08);
    porc = 1; step(); porc = 0;
    chk("R6 por clear", status, 8'h00);

    // R7 new next-ID bit
    nnid = 1; step(); nnid = 0;
    clrf = 1; porc = 1; step(); clrf = 0; porc = 0;
    chk("R7 flag clears ignored", status, 8'h10);
    chk("R9 commands keep mask", mask, 8'h1F);
    nrd = 1; step(); nrd = 0;
    chk("R7 read clears", status, 8'h00);

    // R8 collision
    rcfg = 1; clrf = 1; nnid = 1; nrd = 1; step();
    rcfg = 0; clrf = 0; nnid = 0; nrd = 0;
    chk("R8 set wins", status, 8'h14);
    clrf = 1; nrd = 1; step(); clrf = 0; nrd = 0;

    // Random phase against the model
    for (int i = 0; i < 600; i++) begin
      txav  = $urandom_range(0, 1);
      rxinh = $urandom_range(0, 1);
      rcfg  = ($urandom_range(0, 7) == 0);
      nakx  = ($urandom_range(0, 7) == 0);
      nnid  = ($urandom_range(0, 7) == 0);
      clrf  = ($urandom_range(0, 5) == 0);
      porc  = ($urandom_range(0, 5) == 0);
      nrd   = ($urandom_range(0, 5) == 0);
      wen   = ($urandom_range(0, 9) == 0);
      waddr = 3'($urandom_range(0, 1));
      wdata = 8'($urandom);
      step();
    end
    {txav, rxinh, rcfg, nakx, nnid, clrf, porc, nrd, wen} = '0;
    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule